// File: doc/BRIEF.md
# Length-Addressed Three-Wire Control Receiver

This block receives control words from a host over a three-wire serial bus made of an enable strobe, a bit clock and one data wire that carries data both ways. The host pulls enable low and sends bits on the data wire. The receiver takes one bit at each falling edge of the bit clock and counts the edges. It is picked out from the other devices on the same bus only by the length of the word. When enable rises again, the word is taken only if exactly nine clock pulses arrived. Any other length is ignored.

A nine-bit word carries six data bits and then three subaddress bits. Each field is sent least significant bit first. The subaddress chooses one of eight control settings for a video path: brightness, contrast, colour enable, insertion block, sync/async selection, internal/external video selection, and two colour-difference saturation levels. After a word is taken, and while enable stays high, the receiver sends back a reply of up to four bits on the data wire, one bit per host clock, through an output enable. The reply is sent once. The first complete transmission after reset only primes the receiver and changes nothing.

All bus inputs are oversampled by the system clock through two-stage synchronizers. The edges are found in that clock domain.

Top module: `vctl_rx_top`

## Requirements
- R1: While enable is low, each falling bit-clock edge stores the data-wire level. Bit k of the word (k = 0 first) is stored at position k: positions 0..5 form the data field d[5:0], and positions 6..8 form the subaddress a[2:0]. A falling bit-clock edge while enable is high stores nothing.
- R2: At the rising edge of enable, a word is accepted only if the count of falling edges is exactly 9. With any other count, all control outputs stay the same and no reply is driven.
- R3: The first rising edge of enable after reset ends a transmission that is discarded. No control output changes and no reply follows.
- R4: Subaddress 0 loads brightness and subaddress 1 loads contrast, each with d[5:1]. d[0] has no effect on either.
- R5: Subaddress 6 loads the B-Y saturation and subaddress 7 loads the R-Y saturation, each with all of d[5:0].
- R6: Subaddress 2 loads colour enable from d[5] (1 = on). Subaddress 4 loads the sync select from d[5] (1 = async). Subaddress 5 loads the video select from d[5] (1 = internal). Subaddress 3 loads the insertion block from d[4] (1 = insertion not allowed).
- R7: After reset, every control output is 0: brightness, contrast and saturations at minimum, colour off, insertion allowed, sync mode, external video. The data output enable is low.
- R8: An accepted word changes only the register its subaddress selects. Every bit of that register takes its new value in the same system clock cycle.
- R9: After an accepted word, each falling bit-clock edge while enable is high raises the data output enable and drives one reply bit. The first bit goes out at the first such edge. The bits are sent in the order d[4], d[5], a[0], a[1] of the accepted word.
- R10: After REPLY_LEN reply bits (1 to 4, default 4), the next falling bit-clock edge releases the data wire, and later edges are ignored until another word is accepted.
- R11: A falling edge of enable releases the data wire at once, even if the reply is not finished. When released, the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Bus enable strobe, low while a word is sent |
| bus_clk_i | input | 1 | Bus bit clock from the host |
| bus_data_i | input | 1 | Data wire, input side |
| bus_data_o | output | 1 | Data wire, output side (reply bit) |
| bus_data_oe_o | output | 1 | Drive enable for the data wire |
| bright_o | output | 5 | Brightness setting |
| contrast_o | output | 5 | Contrast setting |
| colour_on_o | output | 1 | Colour enable, 1 = on |
| insert_block_o | output | 1 | 1 = insertion not allowed |
| async_sync_o | output | 1 | 1 = async sync source |
| int_video_o | output | 1 | 1 = internal video selected |
| sat_by_o | output | 6 | B-Y saturation setting |
| sat_ry_o | output | 6 | R-Y saturation setting |

## Verification
Every pair of subaddress (0..7) and data value (0..63) is sent as a nine-bit word. Each one is checked against a model register file, and the reply of each is read back. This separates a field taken from the wrong bit position, a wrong bit order or a write to a neighbouring register: a sweep of all values catches each of these, where a few hand-picked values could miss them. Words of 8 and 10 clocks show that the length check rejects them, and a discarded first word shows the priming rule. A reply cut off by enable falling, and extra clocks after a full reply, show that the wire is released and that the reply is sent only once.

// File: rtl/vctl_pkg.sv
package vctl_pkg;
  localparam int WORD_BITS = 9;
  localparam int DATA_BITS = 6;
  localparam int ADDR_BITS = 3;
  localparam int LVL_BITS  = DATA_BITS - 1;
  localparam int REPLY_MAX = 4;

  typedef enum logic [ADDR_BITS-1:0] {
    SA_BRIGHT   = 3'd0,
    SA_CONTRAST = 3'd1,
    SA_COLOUR   = 3'd2,
    SA_INSERT   = 3'd3,
    SA_SYNC     = 3'd4,
    SA_VIDSEL   = 3'd5,
    SA_SAT_BY   = 3'd6,
    SA_SAT_RY   = 3'd7
  } subaddr_e;

  typedef struct packed {
    logic [LVL_BITS-1:0]  bright;
    logic [LVL_BITS-1:0]  contrast;
    logic                 colour_on;
    logic                 insert_block;
    logic                 async_sync;
    logic                 int_video;
    logic [DATA_BITS-1:0] sat_by;
    logic [DATA_BITS-1:0] sat_ry;
  } ctl_t;
endpackage

// File: rtl/vctl_bus_sync.sv
module vctl_bus_sync #(
  parameter int W = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  // idle bus level is high on every line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
      prev_q <= '1;
    end else begin
      stg_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/vctl_word_rx.sv
module vctl_word_rx
  import vctl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_lvl_i,
  input  logic                 en_rise_i,
  input  logic                 en_fall_i,
  input  logic                 clk_fall_i,
  input  logic                 data_lvl_i,
  output logic                 accept_o,
  output logic [WORD_BITS-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(WORD_BITS);

  logic [CNT_W-1:0]     cnt_q;
  logic [WORD_BITS-1:0] shift_q;
  logic                 primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shift_q  <= '0;
      primed_q <= 1'b0;
    end else begin
      if (en_fall_i) begin
        cnt_q <= '0;
      end else if (clk_fall_i && !en_lvl_i) begin
        for (int i = 0; i < WORD_BITS; i++)
          if (cnt_q == CNT_W'(i)) shift_q[i] <= data_lvl_i;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (en_rise_i) primed_q <= 1'b1;
    end
  end

  assign accept_o = en_rise_i && primed_q && (cnt_q == CNT_HIT);
  assign word_o   = shift_q;

  // R1: clock edges while enable is high leave the word alone
  p_shift_only_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_fall_i && en_lvl_i && !en_fall_i) |=> $stable(shift_q));

  // R2: a new word always starts counting from zero
  p_count_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fall_i |=> (cnt_q == '0));
endmodule

// File: rtl/vctl_reg_bank.sv
module vctl_reg_bank
  import vctl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [WORD_BITS-1:0] word_i,
  output ctl_t                 ctl_o
);
  logic [DATA_BITS-1:0] dat;
  subaddr_e             sa;
  ctl_t                 ctl_q;

  assign dat = word_i[DATA_BITS-1:0];
  assign sa  = subaddr_e'(word_i[WORD_BITS-1:DATA_BITS]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_i) begin
      unique case (sa)
        SA_BRIGHT:   ctl_q.bright       <= dat[DATA_BITS-1:1];
        SA_CONTRAST: ctl_q.contrast     <= dat[DATA_BITS-1:1];
        SA_COLOUR:   ctl_q.colour_on    <= dat[DATA_BITS-1];
        SA_INSERT:   ctl_q.insert_block <= dat[DATA_BITS-2];
        SA_SYNC:     ctl_q.async_sync   <= dat[DATA_BITS-1];
        SA_VIDSEL:   ctl_q.int_video    <= dat[DATA_BITS-1];
        SA_SAT_BY:   ctl_q.sat_by       <= dat;
        SA_SAT_RY:   ctl_q.sat_ry       <= dat;
        default:     ctl_q              <= ctl_q;
      endcase
    end
  end

  assign ctl_o = ctl_q;

  // R2 R8: registers move only on an accepted word
  p_hold_without_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctl_q));

  // R8: saturation registers untouched by a word for another subaddress
  p_sat_isolated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (sa != SA_SAT_BY)) |=> $stable(ctl_q.sat_by));
endmodule

// File: rtl/vctl_reply_tx.sv
module vctl_reply_tx
  import vctl_pkg::*;
#(
  parameter int REPLY_LEN = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 accept_i,
  input  logic [WORD_BITS-1:0] word_i,
  input  logic                 en_lvl_i,
  input  logic                 en_fall_i,
  input  logic                 clk_fall_i,
  output logic                 data_o,
  output logic                 oe_o
);
  localparam int IDX_W = $clog2(REPLY_MAX + 1);
  localparam int SEL_W = $clog2(REPLY_MAX);
  localparam logic [IDX_W-1:0] LEN = IDX_W'(REPLY_LEN);

  logic [REPLY_MAX-1:0] rep_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 armed_q, oe_q, bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q   <= '0;
      idx_q   <= '0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
      bit_q   <= 1'b0;
    end else if (accept_i) begin
      // sent first to last: d4, d5, a0, a1
      rep_q   <= {word_i[DATA_BITS+1], word_i[DATA_BITS],
                  word_i[DATA_BITS-1], word_i[DATA_BITS-2]};
      idx_q   <= '0;
      armed_q <= 1'b1;
      oe_q    <= 1'b0;
    end else if (en_fall_i) begin
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (clk_fall_i && en_lvl_i && armed_q) begin
      if (idx_q < LEN) begin
        bit_q <= rep_q[idx_q[SEL_W-1:0]];
        oe_q  <= 1'b1;
        idx_q <= idx_q + 1'b1;
      end else begin
        oe_q    <= 1'b0;
        armed_q <= 1'b0;
      end
    end
  end

  assign oe_o   = oe_q;
  assign data_o = oe_q & bit_q;

  // R11: enable falling frees the wire on the next cycle
  p_release_on_en_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fall_i |=> !oe_o);

  // R10: never more reply bits than configured
  p_reply_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LEN);

  // R9: the wire is only taken on a bit-clock falling edge
  p_drive_on_clk_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(clk_fall_i));
endmodule

// File: rtl/vctl_rx_top.sv
module vctl_rx_top
  import vctl_pkg::*;
#(
  parameter int REPLY_LEN   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_en_i,
  input  logic                 bus_clk_i,
  input  logic                 bus_data_i,
  output logic                 bus_data_o,
  output logic                 bus_data_oe_o,
  output logic [LVL_BITS-1:0]  bright_o,
  output logic [LVL_BITS-1:0]  contrast_o,
  output logic                 colour_on_o,
  output logic                 insert_block_o,
  output logic                 async_sync_o,
  output logic                 int_video_o,
  output logic [DATA_BITS-1:0] sat_by_o,
  output logic [DATA_BITS-1:0] sat_ry_o
);
  localparam int L_EN = 2, L_CK = 1, L_DA = 0;

  logic [2:0]           lvl, rise, fall;
  logic                 accept;
  logic [WORD_BITS-1:0] word;
  ctl_t                 ctl;

  vctl_bus_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({bus_en_i, bus_clk_i, bus_data_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  vctl_word_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_lvl_i   (lvl[L_EN]),
    .en_rise_i  (rise[L_EN]),
    .en_fall_i  (fall[L_EN]),
    .clk_fall_i (fall[L_CK]),
    .data_lvl_i (lvl[L_DA]),
    .accept_o   (accept),
    .word_o     (word)
  );

  vctl_reg_bank u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (accept),
    .word_i (word),
    .ctl_o  (ctl)
  );

  vctl_reply_tx #(.REPLY_LEN(REPLY_LEN)) u_reply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .word_i     (word),
    .en_lvl_i   (lvl[L_EN]),
    .en_fall_i  (fall[L_EN]),
    .clk_fall_i (fall[L_CK]),
    .data_o     (bus_data_o),
    .oe_o       (bus_data_oe_o)
  );

  assign bright_o       = ctl.bright;
  assign contrast_o     = ctl.contrast;
  assign colour_on_o    = ctl.colour_on;
  assign insert_block_o = ctl.insert_block;
  assign async_sync_o   = ctl.async_sync;
  assign int_video_o    = ctl.int_video;
  assign sat_by_o       = ctl.sat_by;
  assign sat_ry_o       = ctl.sat_ry;

  // R3: the priming transmission never writes
  p_first_word_discarded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> !accept);
endmodule

// File: tb/sim_vctl_rx_top.sv
`timescale 1ns/1ps
module sim_vctl_rx_top;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, sck = 1'b1, sdi = 1'b0;
  logic sdo, soe, col, ins, asy, intv;
  logic [4:0] bri, con;
  logic [5:0] sby, sry;
  int n_chk = 0, n_bad = 0;

  // model state
  logic [4:0] m_bri = '0, m_con = '0;
  logic m_col = 0, m_ins = 0, m_asy = 0, m_int = 0;
  logic [5:0] m_sby = '0, m_sry = '0;

  always #10 clk = ~clk;

  vctl_rx_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_en_i(en), .bus_clk_i(sck), .bus_data_i(sdi),
    .bus_data_o(sdo), .bus_data_oe_o(soe),
    .bright_o(bri), .contrast_o(con), .colour_on_o(col),
    .insert_block_o(ins), .async_sync_o(asy), .int_video_o(intv),
    .sat_by_o(sby), .sat_ry_o(sry)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] w, input int nbits);
    en = 1'b0; wait_hp();
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 9) ? w[i] : 1'b0;
      wait_hp();
      sck = 1'b0; wait_hp();
      sck = 1'b1;
    end
    wait_hp();
    en = 1'b1; wait_hp();
  endtask

  task automatic chk_regs(input string tag);
    logic [25:0] act, exp;
    act = {bri, con, col, ins, asy, intv, sby, sry};
    exp = {m_bri, m_con, m_col, m_ins, m_asy, m_int, m_sby, m_sry};
    chk(act == exp, tag, 32'(act), 32'(exp));
  endtask

  // one reply clock: low phase sampled at its end
  task automatic rd_bit(output logic oe, output logic d);
    sck = 1'b0; wait_hp();
    oe = soe; d = sdo;
    sck = 1'b1; wait_hp();
  endtask

  task automatic model(input logic [2:0] a, input logic [5:0] d);
    case (a)
      3'd0: m_bri = d[5:1];
      3'd1: m_con = d[5:1];
      3'd2: m_col = d[5];
      3'd3: m_ins = d[4];
      3'd4: m_asy = d[5];
      3'd5: m_int = d[5];
      3'd6: m_sby = d;
      default: m_sry = d;
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic oe, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_hp();
    // R7 reset state
    chk_regs("R7 reset values");
    chk(soe == 1'b0, "R7 oe after reset", 32'(soe), 0);

    // R3: first full word is only priming
    send({3'd6, 6'h3f}, 9);
    chk_regs("R3 first word discarded");
    rd_bit(oe, d);
    chk(oe == 1'b0, "R3 no reply to priming word", 32'(oe), 0);

    // main sweep: every subaddress x every data value
    for (int a = 0; a < 8; a++) begin
      for (int v = 0; v < 64; v++) begin
        logic [2:0] aa; logic [5:0] dd; logic [3:0] rep;
        aa = 3'(a); dd = 6'(v);
        send({aa, dd}, 9);
        model(aa, dd);
        case (a)
          0, 1: chk_regs("R4 level from d[5:1], d[0] ignored");
          6, 7: chk_regs("R5 saturation from d[5:0]");
          default: chk_regs("R6 flag bit and R8 isolation");
        endcase
        rep = {aa[1], aa[0], dd[5], dd[4]};
        for (int k = 0; k < 4; k++) begin
          rd_bit(oe, d);
          chk(oe == 1'b1, "R9 reply oe", 32'(oe), 1);
          chk(d == rep[k], "R9 reply bit order d4 d5 a0 a1 / R1 field position", 32'(d), 32'(rep[k]));
        end
        rd_bit(oe, d);
        chk(oe == 1'b0, "R10 wire released after reply", 32'(oe), 0);
        rd_bit(oe, d);
        chk(oe == 1'b0 && d == 1'b0, "R10 extra clocks ignored", 32'({oe, d}), 0);
      end
    end

    // R2: wrong lengths leave everything unchanged and give no reply
    send({3'd6, 6'h15}, 8);
    chk_regs("R2 8-clock word rejected");
    rd_bit(oe, d);
    chk(oe == 1'b0, "R2 no reply to 8-clock word", 32'(oe), 0);
    send({3'd7, 6'h2a}, 10);
    chk_regs("R2 10-clock word rejected");
    rd_bit(oe, d);
    chk(oe == 1'b0, "R2 no reply to 10-clock word", 32'(oe), 0);

    // R11: reply cut by enable falling
    send({3'd1, 6'h30}, 9);
    model(3'd1, 6'h30);
    chk_regs("R4 contrast after reject tests");
    rd_bit(oe, d);
    chk(oe == 1'b1 && d == 1'b1, "R9 first reply bit d4", 32'({oe, d}), 3);
    en = 1'b0; wait_hp();
    chk(soe == 1'b0 && sdo == 1'b0, "R11 enable fall releases wire", 32'({soe, sdo}), 0);
    en = 1'b1; wait_hp();
    rd_bit(oe, d);
    chk(oe == 1'b0, "R10 reply only once", 32'(oe), 0);
    chk_regs("R2 empty word changes nothing");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule